// File: doc/BRIEF.md
# Serial Flash Boot Copy Engine

After reset, a controller asks this block to copy two images out of a serial flash. The block acts as SPI master and works on its own from that point. It first streams a large program image into an external-memory port. It then streams a small vector image into an on-chip RAM port. After each copy it deselects the flash, reselects it, and reads only the leading bytes of that image a second time. It compares those bytes against what the target memory returns. Each image has its own sticky mismatch flag. A single "boot ok" output rises only when the whole sequence has finished and both comparisons found no difference.

Every flash access is one session. A session pulls chip select low, sends a read opcode and a 24-bit start address, and then clocks out filler bytes. The flash answers each filler byte with one data byte. The session ends by raising chip select. A run always has four sessions, in a fixed order: program copy, program check, vector copy, vector check. Chip select rests high for a guaranteed interval between sessions.

Top module: `boot_copy_engine`

## Requirements
- R1: While reset is held and after reset is released, chip select is high, SCLK is low, and busy, done, main_err, vec_err and boot_ok are all low.
- R2: Each session starts by shifting out the opcode 0x03 and then the 24-bit start address, most significant bit first, in SPI mode 0. SCLK idles low, MISO is sampled on the rising edge, and MOSI changes only while SCLK is low.
- R3: In the program copy session, flash byte MAIN_BASE+n goes to mm_addr n with mm_we high, for every n from 0 to MAIN_LEN-1. Each address is written exactly once, and only while chip select is low.
- R4: In the vector copy session, flash byte VEC_BASE+n goes to vr_addr n with vr_we high, for every n from 0 to VEC_LEN-1. Each address is written exactly once.
- R5: A run has exactly four sessions, in this order: program copy (MAIN_BASE, MAIN_LEN data bytes), program check (MAIN_BASE, MAIN_CHK bytes), vector copy (VEC_BASE, VEC_LEN bytes), and vector check (VEC_BASE, VEC_CHK bytes). The check sessions read back target addresses 0 to CHK-1 with a one-cycle read latency. A mismatch at an address at or above the check length is never reported.
- R6: Between sessions, chip select stays high for at least two SCLK periods (4*CLK_DIV clock cycles). SCLK stays low whenever chip select is high.
- R7: A difference in the program check sets main_err. The vector copy and vector check still run, vec_err is unaffected, and boot_ok stays low.
- R8: A difference in the vector check sets vec_err only. main_err stays low and boot_ok stays low.
- R9: done rises after the fourth session, in the same cycle that busy falls. boot_ok is high exactly when done is high and neither error flag is set. done and the error flags hold until the next start, and that start clears them.
- R10: start is ignored while a run is in progress. No extra session occurs, and no session occurs after done until start is pulsed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a boot run when idle |
| spi_sclk | output | 1 | SPI serial clock, mode 0 |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| mm_we | output | 1 | Program memory write strobe |
| mm_re | output | 1 | Program memory read strobe |
| mm_addr | output | $clog2(MAIN_LEN+1) | Program memory byte address |
| mm_wdata | output | 8 | Program memory write data |
| mm_rdata | input | 8 | Program memory read data, one cycle after mm_re |
| vr_we | output | 1 | Vector RAM write strobe |
| vr_re | output | 1 | Vector RAM read strobe |
| vr_addr | output | $clog2(VEC_LEN+1) | Vector RAM byte address |
| vr_wdata | output | 8 | Vector RAM write data |
| vr_rdata | input | 8 | Vector RAM read data, one cycle after vr_re |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| main_err | output | 1 | Program check mismatch |
| vec_err | output | 1 | Vector check mismatch |
| boot_ok | output | 1 | Run finished with both checks clean |

## Verification
The bench builds the block with a 40-byte program image, of which the first 16 bytes are checked, and a 12-byte vector image that is checked in full. CLK_DIV is 2. With these sizes every session of a run fits into a few thousand cycles, so one simulation can hold several complete runs back to back. The bench's memory models can flip one readback byte. Placing that byte inside the program window, inside the vector window, or just past the end of the program window exercises each error flag on its own and the leading-portion limit.

// File: rtl/bce_pkg.sv
package bce_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_GAP,
    S_LAUNCH,
    S_WAIT,
    S_FIN
  } seq_st_e;

  localparam int          HDR_BYTES = 4;
  localparam logic [7:0]  OP_READ   = 8'h03;

  // Header byte k of a read session: opcode, then address high to low.
  function automatic logic [7:0] hdr_byte(logic [23:0] addr, logic [1:0] k);
    case (k)
      2'd0:    return OP_READ;
      2'd1:    return addr[23:16];
      2'd2:    return addr[15:8];
      default: return addr[7:0];
    endcase
  endfunction

endpackage

// File: rtl/bce_spi_shift.sv
module bce_spi_shift #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);

  localparam int CW = $clog2(CLK_DIV + 1);

  logic [CW-1:0] tick_cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    tx_sh;
  logic          busy;
  logic          half_tick;

  assign half_tick = busy && (tick_cnt == CW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      bit_idx  <= '0;
      tx_sh    <= '0;
      rx       <= '0;
      busy     <= 1'b0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy     <= 1'b1;
        tx_sh    <= tx;
        mosi     <= tx[7];
        tick_cnt <= '0;
        bit_idx  <= '0;
        sclk     <= 1'b0;
      end else if (busy) begin
        if (half_tick) begin
          tick_cnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_idx == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 3'd1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
              mosi    <= tx_sh[6];
            end
          end
        end else begin
          tick_cnt <= tick_cnt + CW'(1);
        end
      end
    end
  end

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi)); // R2
  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk); // R6

endmodule

// File: rtl/bce_seq.sv
module bce_seq
  import bce_pkg::*;
#(
  parameter int          MAIN_LEN  = 1167724,
  parameter int          MAIN_CHK  = 1000,
  parameter int          VEC_LEN   = 80,
  parameter int          VEC_CHK   = 80,
  parameter logic [23:0] MAIN_BASE = 24'h110000,
  parameter logic [23:0] VEC_BASE  = 24'h320000,
  parameter int          GAP_CYC   = 8,
  parameter int          CNT_W     = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sh_done,
  output logic             sh_go,
  output logic [7:0]       sh_tx,
  output logic             cs_n,
  output logic             busy,
  output logic             done,
  output logic [1:0]       pass,
  output logic             data_ev,
  output logic [CNT_W-1:0] data_idx
);

  localparam int GAP_W = $clog2(GAP_CYC + 1);

  seq_st_e          st;
  logic [CNT_W-1:0] idx;
  logic [GAP_W-1:0] gapc;
  logic             byte_fin;
  logic             sess_end;

  // Index of the final byte of the session run in pass p.
  function automatic logic [CNT_W-1:0] last_idx(logic [1:0] p);
    case (p)
      2'd0:    return CNT_W'(MAIN_LEN + HDR_BYTES - 1);
      2'd1:    return CNT_W'(MAIN_CHK + HDR_BYTES - 1);
      2'd2:    return CNT_W'(VEC_LEN  + HDR_BYTES - 1);
      default: return CNT_W'(VEC_CHK  + HDR_BYTES - 1);
    endcase
  endfunction

  function automatic logic [7:0] next_tx(logic [1:0] p, logic [CNT_W-1:0] i);
    logic [23:0] base;
    base = p[1] ? VEC_BASE : MAIN_BASE;
    if (i < CNT_W'(HDR_BYTES)) return hdr_byte(base, i[1:0]);
    return 8'h00;
  endfunction

  assign byte_fin = (st == S_WAIT) && sh_done;
  assign sess_end = byte_fin && (idx == last_idx(pass));
  assign data_ev  = byte_fin && (idx >= CNT_W'(HDR_BYTES));
  assign data_idx = idx - CNT_W'(HDR_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      idx   <= '0;
      gapc  <= '0;
      pass  <= '0;
      cs_n  <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
      sh_go <= 1'b0;
      sh_tx <= '0;
    end else begin
      sh_go <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          busy <= 1'b1;
          done <= 1'b0;
          pass <= '0;
          gapc <= '0;
          st   <= S_GAP;
        end
        S_GAP: begin
          if (gapc == GAP_W'(GAP_CYC - 1)) begin
            gapc <= '0;
            cs_n <= 1'b0;
            idx  <= '0;
            st   <= S_LAUNCH;
          end else begin
            gapc <= gapc + GAP_W'(1);
          end
        end
        S_LAUNCH: begin
          sh_go <= 1'b1;
          sh_tx <= next_tx(pass, idx);
          st    <= S_WAIT;
        end
        S_WAIT: if (sh_done) begin
          if (sess_end) begin
            cs_n <= 1'b1;
            if (pass == 2'd3) begin
              st <= S_FIN;
            end else begin
              pass <= pass + 2'd1;
              st   <= S_GAP;
            end
          end else begin
            idx <= idx + CNT_W'(1);
            st  <= S_LAUNCH;
          end
        end
        S_FIN: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && st != S_FIN) |=> busy); // R10
  AST_PASS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (pass != $past(pass)) |-> (pass == $past(pass) + 2'd1) || (pass == 2'd0)); // R5

endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine #(
  parameter int          MAIN_LEN  = 1167724,
  parameter int          MAIN_CHK  = 1000,
  parameter int          VEC_LEN   = 80,
  parameter int          VEC_CHK   = 80,
  parameter logic [23:0] MAIN_BASE = 24'h110000,
  parameter logic [23:0] VEC_BASE  = 24'h320000,
  parameter int          CLK_DIV   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  output logic                          spi_sclk,
  output logic                          spi_mosi,
  input  logic                          spi_miso,
  output logic                          spi_cs_n,
  output logic                          mm_we,
  output logic                          mm_re,
  output logic [$clog2(MAIN_LEN+1)-1:0] mm_addr,
  output logic [7:0]                    mm_wdata,
  input  logic [7:0]                    mm_rdata,
  output logic                          vr_we,
  output logic                          vr_re,
  output logic [$clog2(VEC_LEN+1)-1:0]  vr_addr,
  output logic [7:0]                    vr_wdata,
  input  logic [7:0]                    vr_rdata,
  output logic                          busy,
  output logic                          done,
  output logic                          main_err,
  output logic                          vec_err,
  output logic                          boot_ok
);

  localparam int MA_W    = $clog2(MAIN_LEN + 1);
  localparam int VA_W    = $clog2(VEC_LEN + 1);
  localparam int CNT_W   = $clog2(MAIN_LEN + 5);
  localparam int GAP_CYC = 4 * CLK_DIV;
  localparam int HC_W    = $clog2(GAP_CYC + 1);

  logic             sh_go, sh_done;
  logic [7:0]       sh_tx, sh_rx;
  logic [1:0]       pass;
  logic             data_ev;
  logic [CNT_W-1:0] data_idx;
  logic             is_check;
  logic             to_vec;
  logic             cmp_pend;
  logic             cmp_vec;
  logic [7:0]       cmp_val;
  logic [7:0]       cmp_rd;

  bce_spi_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (sh_go),
    .tx   (sh_tx),
    .miso (spi_miso),
    .sclk (spi_sclk),
    .mosi (spi_mosi),
    .done (sh_done),
    .rx   (sh_rx)
  );

  bce_seq #(
    .MAIN_LEN (MAIN_LEN),
    .MAIN_CHK (MAIN_CHK),
    .VEC_LEN  (VEC_LEN),
    .VEC_CHK  (VEC_CHK),
    .MAIN_BASE(MAIN_BASE),
    .VEC_BASE (VEC_BASE),
    .GAP_CYC  (GAP_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .sh_done (sh_done),
    .sh_go   (sh_go),
    .sh_tx   (sh_tx),
    .cs_n    (spi_cs_n),
    .busy    (busy),
    .done    (done),
    .pass    (pass),
    .data_ev (data_ev),
    .data_idx(data_idx)
  );

  // Pass decode: bit 0 selects the check session, bit 1 the vector target.
  assign is_check = pass[0];
  assign to_vec   = pass[1];

  assign mm_we    = data_ev && !is_check && !to_vec;
  assign mm_re    = data_ev &&  is_check && !to_vec;
  assign vr_we    = data_ev && !is_check &&  to_vec;
  assign vr_re    = data_ev &&  is_check &&  to_vec;
  assign mm_addr  = MA_W'(data_idx);
  assign vr_addr  = VA_W'(data_idx);
  assign mm_wdata = sh_rx;
  assign vr_wdata = sh_rx;

  assign cmp_rd   = cmp_vec ? vr_rdata : mm_rdata;
  assign boot_ok  = done && !main_err && !vec_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_pend <= 1'b0;
      cmp_vec  <= 1'b0;
      cmp_val  <= '0;
      main_err <= 1'b0;
      vec_err  <= 1'b0;
    end else begin
      cmp_pend <= data_ev && is_check;
      if (data_ev && is_check) begin
        cmp_vec <= to_vec;
        cmp_val <= sh_rx;
      end
      if (start && !busy) begin
        main_err <= 1'b0;
        vec_err  <= 1'b0;
      end else if (cmp_pend && (cmp_rd != cmp_val)) begin
        if (cmp_vec) vec_err  <= 1'b1;
        else         main_err <= 1'b1;
      end
    end
  end

  // Cycles chip select has been high, saturating; used by the gap check.
  logic [HC_W-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             hi_cnt <= '0;
    else if (!spi_cs_n)                     hi_cnt <= '0;
    else if (hi_cnt != HC_W'(GAP_CYC))      hi_cnt <= hi_cnt + HC_W'(1);
  end

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $past(spi_cs_n)) |-> (hi_cnt >= HC_W'(GAP_CYC - 1))); // R6
  AST_CS_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R6
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mm_we, mm_re, vr_we, vr_re})); // R5
  AST_WRITE_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_we || vr_we) |-> !spi_cs_n); // R3
  AST_ERR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && $past(done)) |-> ($stable(main_err) && $stable(vec_err))); // R9

endmodule

// File: tb/boot_copy_engine_tb_top.sv
module boot_copy_engine_tb_top;

  localparam int          MAIN_LEN  = 40;
  localparam int          MAIN_CHK  = 16;
  localparam int          VEC_LEN   = 12;
  localparam int          VEC_CHK   = 12;
  localparam logic [23:0] MAIN_BASE = 24'h110000;
  localparam logic [23:0] VEC_BASE  = 24'h320000;
  localparam int          CLK_DIV   = 2;
  localparam int          MA_W      = $clog2(MAIN_LEN + 1);
  localparam int          VA_W      = $clog2(VEC_LEN + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic spi_sclk, spi_mosi, spi_cs_n;
  logic spi_miso = 1'b0;
  logic mm_we, mm_re, vr_we, vr_re;
  logic [MA_W-1:0] mm_addr;
  logic [VA_W-1:0] vr_addr;
  logic [7:0] mm_wdata, vr_wdata;
  logic [7:0] mm_rdata = 8'h00;
  logic [7:0] vr_rdata = 8'h00;
  logic busy, done, main_err, vec_err, boot_ok;

  always #5 clk = ~clk;

  boot_copy_engine #(
    .MAIN_LEN(MAIN_LEN), .MAIN_CHK(MAIN_CHK), .VEC_LEN(VEC_LEN), .VEC_CHK(VEC_CHK),
    .MAIN_BASE(MAIN_BASE), .VEC_BASE(VEC_BASE), .CLK_DIV(CLK_DIV)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
    .mm_we(mm_we), .mm_re(mm_re), .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
    .vr_we(vr_we), .vr_re(vr_re), .vr_addr(vr_addr), .vr_wdata(vr_wdata), .vr_rdata(vr_rdata),
    .busy(busy), .done(done), .main_err(main_err), .vec_err(vec_err), .boot_ok(boot_ok)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fdata(logic [23:0] a);
    logic [7:0] p;
    p = a[7:0] * 8'd13;
    return p ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  // ---------------- flash model (mode 0 slave) ----------------
  int          bitcnt = 0;
  logic [31:0] hdr = '0;
  logic [7:0]  obyte = '0;

  always @(negedge spi_cs_n) begin
    bitcnt = 0;
    hdr    = '0;
  end
  always @(posedge spi_sclk) if (spi_cs_n === 1'b0) begin
    if (bitcnt < 32) hdr = {hdr[30:0], spi_mosi};
    bitcnt++;
  end
  always @(negedge spi_sclk) if (spi_cs_n === 1'b0 && bitcnt >= 32) begin
    if (bitcnt % 8 == 0) obyte = fdata(hdr[23:0] + 24'((bitcnt - 32) / 8));
    spi_miso = obyte[7 - (bitcnt % 8)];
  end

  // ---------------- memory models ----------------
  logic [7:0] main_mem [MAIN_LEN];
  logic [7:0] vec_mem  [VEC_LEN];
  int bad_main = -1;
  int bad_vec  = -1;
  int main_wr  = 0;
  int vec_wr   = 0;

  always @(posedge clk) begin
    if (mm_we) begin main_mem[int'(mm_addr)] <= mm_wdata; main_wr <= main_wr + 1; end
    if (vr_we) begin vec_mem[int'(vr_addr)]  <= vr_wdata; vec_wr  <= vec_wr + 1;  end
    if (mm_re) mm_rdata <= main_mem[int'(mm_addr)] ^ ((int'(mm_addr) == bad_main) ? 8'h01 : 8'h00);
    if (vr_re) vr_rdata <= vec_mem[int'(vr_addr)]  ^ ((int'(vr_addr) == bad_vec)  ? 8'h01 : 8'h00);
  end

  // ---------------- scoreboard ----------------
  logic [31:0] exp_hdr [$];
  int          exp_len [$];

  task automatic push_run();
    exp_hdr.push_back({8'h03, MAIN_BASE}); exp_len.push_back(MAIN_LEN);
    exp_hdr.push_back({8'h03, MAIN_BASE}); exp_len.push_back(MAIN_CHK);
    exp_hdr.push_back({8'h03, VEC_BASE});  exp_len.push_back(VEC_LEN);
    exp_hdr.push_back({8'h03, VEC_BASE});  exp_len.push_back(VEC_CHK);
  endtask

  always @(posedge spi_cs_n) if (bitcnt > 0) begin
    if (exp_hdr.size() == 0) begin
      chk(1'b0, "R10", "unexpected session", bitcnt, 0);
    end else begin
      logic [31:0] eh;
      int          el;
      eh = exp_hdr.pop_front();
      el = exp_len.pop_front();
      chk(hdr == eh, "R2", "session header", hdr, eh);
      chk((bitcnt - 32) / 8 == el, "R5", "session data bytes", (bitcnt - 32) / 8, el);
    end
    bitcnt = 0;
  end

  // chip select high time, counted on falling clock edges
  int hi_cyc = 0;
  always @(negedge clk) if (spi_cs_n === 1'b1) hi_cyc++;
  always @(negedge spi_cs_n) begin
    chk(hi_cyc >= 4 * CLK_DIV, "R6", "cs high gap cycles", hi_cyc, 4 * CLK_DIV);
    hi_cyc = 0;
  end

  // sclk must be low while deselected
  always @(negedge clk) if (rst_n && spi_cs_n === 1'b1 && spi_sclk !== 1'b0)
    chk(1'b0, "R6", "sclk while deselected", spi_sclk, 0);

  // ---------------- driver ----------------
  task automatic run_boot(input bit poke_busy);
    main_wr = 0;
    vec_wr  = 0;
    push_run();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R9", "busy after start", busy, 1);
    chk(done === 1'b0, "R9", "done cleared by start", done, 0);
    if (poke_busy) begin
      repeat (200) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    begin
      int t;
      t = 0;
      while (done !== 1'b1 && t < 20000) begin @(negedge clk); t++; end
      chk(t < 20000, "R9", "run timeout (watchdog)", t, 20000);
    end
    chk(busy === 1'b0, "R9", "busy low at done", busy, 0);
    chk(exp_hdr.size() == 0, "R5", "sessions left unseen", exp_hdr.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1", "spi idle in reset", {spi_cs_n, spi_sclk}, 2'b10);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
    chk({busy, done, main_err, vec_err, boot_ok} === 5'b0, "R1", "status after reset",
        {busy, done, main_err, vec_err, boot_ok}, 0);

    // clean run, start poked while busy
    run_boot(1'b1);
    chk(boot_ok === 1'b1, "R9", "boot_ok clean", boot_ok, 1);
    chk(main_err === 1'b0 && vec_err === 1'b0, "R9", "no errors clean", {main_err, vec_err}, 0);
    chk(main_wr == MAIN_LEN, "R3", "program writes", main_wr, MAIN_LEN);
    chk(vec_wr == VEC_LEN, "R4", "vector writes", vec_wr, VEC_LEN);
    for (int i = 0; i < MAIN_LEN; i++)
      if (main_mem[i] !== fdata(MAIN_BASE + 24'(i)))
        chk(1'b0, "R3", $sformatf("program byte %0d", i), main_mem[i], fdata(MAIN_BASE + 24'(i)));
    n_chk++;
    for (int i = 0; i < VEC_LEN; i++)
      if (vec_mem[i] !== fdata(VEC_BASE + 24'(i)))
        chk(1'b0, "R4", $sformatf("vector byte %0d", i), vec_mem[i], fdata(VEC_BASE + 24'(i)));
    n_chk++;
    repeat (300) @(negedge clk);
    chk(done === 1'b1 && boot_ok === 1'b1, "R9", "done held while idle", {done, boot_ok}, 2'b11);
    chk(spi_cs_n === 1'b1, "R10", "no session after done", spi_cs_n, 1);

    // program readback mismatch
    bad_main = 5;
    run_boot(1'b0);
    chk(main_err === 1'b1, "R7", "main_err set", main_err, 1);
    chk(vec_err === 1'b0, "R7", "vec_err clear", vec_err, 0);
    chk(boot_ok === 1'b0, "R7", "boot_ok low", boot_ok, 0);
    chk(vec_wr == VEC_LEN, "R7", "vector copy still ran", vec_wr, VEC_LEN);

    // vector readback mismatch
    bad_main = -1;
    bad_vec  = 3;
    run_boot(1'b0);
    chk(vec_err === 1'b1, "R8", "vec_err set", vec_err, 1);
    chk(main_err === 1'b0, "R8", "main_err cleared", main_err, 0);
    chk(boot_ok === 1'b0, "R8", "boot_ok low", boot_ok, 0);

    // mismatch beyond the checked window is not seen
    bad_vec  = -1;
    bad_main = MAIN_CHK;
    run_boot(1'b0);
    chk(main_err === 1'b0 && boot_ok === 1'b1, "R5", "outside check window", {main_err, boot_ok}, 2'b01);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule